// File: doc/BRIEF.md
# Byte-Addressed GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped GPIO controller. Every pin owns one byte in each register bank, and only bit 0 of that byte carries meaning. Software sets each pin's direction and output value and reads back the synchronized pin level. It can also arm an interrupt detector on each pin.

Each detector responds to one of three things: a chosen level, a chosen edge, or both edges. A hit sets a per-pin status flag, which software clears by writing to the pin's clear byte. The single interrupt output to the host is a registered OR over all pins of status AND enable. A status flag can therefore latch on a masked pin without raising the interrupt.

Register access uses a simple bus. Writes take effect on the clock edge. Reads are combinational from the address and return the addressed byte in the same cycle.

Top module: `gpio_byte_irq`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0). The enable, status, polarity, edge and dual-edge banks read 0, pin_out is 0 and irq is 0.
- R2: A write to config byte 0x800+p sets bit 0: value 0 makes pin p an output (pin_oe[p]=1) and value 1 makes it an input. pin_out[p] follows bit 0 of output byte 0x900+p.
- R3: A read returns {7'b0, bit} of the addressed byte. The input bank 0xA00+p returns the synchronized pin, which changes two clock edges after pin_in. The clear bank 0xE00 reads 0. Any address outside the banks, or with a pin index of N or more, reads 0.
- R4: With edge byte 0xD00+p at 0, pin p is level-sensitive. Status 0xF00+p sets on every cycle in which the synchronized pin equals polarity byte 0xC00+p (1 = high, 0 = low).
- R5: With edge 1 and dual-edge byte 0xF80+p at 0, status sets on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge has no effect.
- R6: With edge 1 and dual-edge 1, status sets on both rising and falling edges, whatever the polarity.
- R7: Writing a value with bit 0 = 1 to 0xE00+p clears status p. If a detection hits in the same cycle, the set wins, so an active level keeps status set.
- R8: irq is the registered OR over all pins of status AND enable (0xB00+p). A status flag on a pin whose enable is 0 never raises irq.
- R9: After a pin_in change before clock edge k, the resulting status is visible after edge k+2 and irq after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for addr/wdata |
| addr | input | 12 | Byte address |
| wdata | input | 8 | Write data, bit 0 used |
| rdata | output | 8 | Read data for addr, combinational |
| pin_in | input | N | Raw pin levels |
| pin_out | output | N | Output drive values |
| pin_oe | output | N | Output driver enables |
| irq | output | 1 | Aggregated interrupt to host |

## Verification
Read data depends on the address and the current state in the same cycle. A register write shows up after the edge that takes it. The synchronized input becomes readable two edges after a pin change, status one edge later, and irq one edge after status. The bench drives inputs 2 ns after each rising edge and compares every output against a behavioural model on each cycle at that same point. The directed checks count edges explicitly to confirm the k+2 and k+3 delays of R9 and the two-edge input delay of R3.

// File: rtl/gpio_byte_irq.sv
module gpio_byte_irq #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [11:0]  addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq
);
  localparam int IW = $clog2(N);

  logic [N-1:0] cfg, dout, en, pol, edg, dual, status;
  logic [N-1:0] s1, s2, s3;
  logic [N-1:0] hit, rise, fall, lvl, evt, v;
  logic [N-1:0] m_cfg, m_out, m_en, m_pol, m_edg, m_dual, clr;

  wire [4:0]    bank = addr[11:7];
  wire [IW-1:0] idx  = addr[IW-1:0];
  wire          ok   = (addr[6:IW] == '0) && (32'(idx) < N);

  assign hit    = ok ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
  assign m_cfg  = (wr_en && bank == 5'h10) ? hit : '0;
  assign m_out  = (wr_en && bank == 5'h12) ? hit : '0;
  assign m_en   = (wr_en && bank == 5'h16) ? hit : '0;
  assign m_pol  = (wr_en && bank == 5'h18) ? hit : '0;
  assign m_edg  = (wr_en && bank == 5'h1A) ? hit : '0;
  assign m_dual = (wr_en && bank == 5'h1F) ? hit : '0;
  assign clr    = (wr_en && bank == 5'h1C && wdata[0]) ? hit : '0;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign lvl  = ~(s2 ^ pol);
  assign evt  = (~edg & lvl)
              | (edg & dual & (rise | fall))
              | (edg & ~dual & ((pol & rise) | (~pol & fall)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '1;
      dout   <= '0;
      en     <= '0;
      pol    <= '0;
      edg    <= '0;
      dual   <= '0;
      status <= '0;
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      irq    <= 1'b0;
    end else begin
      cfg    <= (cfg  & ~m_cfg)  | (m_cfg  & {N{wdata[0]}});
      dout   <= (dout & ~m_out)  | (m_out  & {N{wdata[0]}});
      en     <= (en   & ~m_en)   | (m_en   & {N{wdata[0]}});
      pol    <= (pol  & ~m_pol)  | (m_pol  & {N{wdata[0]}});
      edg    <= (edg  & ~m_edg)  | (m_edg  & {N{wdata[0]}});
      dual   <= (dual & ~m_dual) | (m_dual & {N{wdata[0]}});
      status <= (status & ~clr) | evt;
      s1     <= pin_in;
      s2     <= s1;
      s3     <= s2;
      irq    <= |(status & en);
    end
  end

  always_comb begin
    case (bank)
      5'h10:   v = cfg;
      5'h12:   v = dout;
      5'h14:   v = s2;
      5'h16:   v = en;
      5'h18:   v = pol;
      5'h1A:   v = edg;
      5'h1E:   v = status;
      5'h1F:   v = dual;
      default: v = '0;
    endcase
  end

  assign rdata   = {7'b0, ok & v[idx]};
  assign pin_oe  = ~cfg;
  assign pin_out = dout;
endmodule

// File: rtl/gpio_byte_irq_chk.sv
module gpio_byte_irq_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [11:0]  addr,
  input logic [7:0]   wdata,
  input logic [7:0]   rdata,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic [N-1:0] en,
  input logic [N-1:0] status,
  input logic [N-1:0] evt
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && pin_oe == '0));

  a_r2_output_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h800 && !wdata[0]) |=> pin_oe[0]);

  a_r3_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[11:7] == 5'h1C) |-> (rdata == 8'h00));

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:1] == 7'b0);

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'hE00 && wdata[0] && !evt[0]) |=> !status[0]);

  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq);
endmodule

bind gpio_byte_irq gpio_byte_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pin_oe(pin_oe), .irq(irq), .en(en), .status(status),
  .evt(evt)
);

// File: tb/gpio_byte_irq_tb.sv
`timescale 1ns/1ps
module gpio_byte_irq_tb;
  localparam int N = 32;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0;
  logic [11:0]  addr = 0;
  logic [7:0]   wdata = 0;
  logic [7:0]   rdata;
  logic [N-1:0] pin_in = 0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq;

  int checks = 0, errors = 0;

  gpio_byte_irq #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  always #5 clk = ~clk;

  bit mc[N], mo[N], me[N], mp[N], md[N], mu[N], ms[N];
  bit q1[N], q2[N], q3[N];
  bit mirq;

  always @(posedge clk) begin
    bit ev[N];
    bit any;
    int p;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mc[i] = 1; mo[i] = 0; me[i] = 0; mp[i] = 0; md[i] = 0; mu[i] = 0;
        ms[i] = 0; q1[i] = 0; q2[i] = 0; q3[i] = 0;
      end
      mirq = 0;
    end else begin
      any = 0;
      for (int i = 0; i < N; i++) begin
        if (!md[i])      ev[i] = (q2[i] == mp[i]);
        else if (mu[i])  ev[i] = (q2[i] != q3[i]);
        else if (mp[i])  ev[i] = q2[i] && !q3[i];
        else             ev[i] = !q2[i] && q3[i];
        if (ms[i] && me[i]) any = 1;
      end
      p = addr[6:0];
      if (wr_en && p < N) begin
        case (addr[11:7])
          5'h10: mc[p] = wdata[0];
          5'h12: mo[p] = wdata[0];
          5'h16: me[p] = wdata[0];
          5'h18: mp[p] = wdata[0];
          5'h1A: md[p] = wdata[0];
          5'h1F: mu[p] = wdata[0];
          5'h1C: if (wdata[0]) ms[p] = 0;
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++) begin
        if (ev[i]) ms[i] = 1;
        q3[i] = q2[i]; q2[i] = q1[i]; q1[i] = pin_in[i];
      end
      mirq = any;
    end
  end

  function automatic bit exp_rd(logic [11:0] a);
    int p = a[6:0];
    if (p >= N) return 0;
    case (a[11:7])
      5'h10: return mc[p];
      5'h12: return mo[p];
      5'h14: return q2[p];
      5'h16: return me[p];
      5'h18: return mp[p];
      5'h1A: return md[p];
      5'h1E: return ms[p];
      5'h1F: return mu[p];
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    for (int i = 0; i < N; i++) begin
      check(pin_oe[i] == !mc[i], "R2 pin_oe", pin_oe[i], !mc[i]);
      check(pin_out[i] == mo[i], "R2 pin_out", pin_out[i], mo[i]);
    end
    check(rdata == {7'b0, exp_rd(addr)}, "R3 rdata", rdata, exp_rd(addr));
    check(irq == mirq, "R8 irq", irq, mirq);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    step();
    wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, bit exp, string tag);
    addr = a;
    #1;
    check(rdata == {7'b0, exp}, tag, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    steps(3);
    rst_n = 1;
    #1;
    check(irq == 0, "R1 irq", irq, 0);
    check(pin_oe == '0, "R1 pin_oe", pin_oe, 0);
    check(pin_out == '0, "R1 pin_out", pin_out, 0);
    rd(12'hB00, 0, "R1 enable");
    rd(12'hF00, 0, "R1 status");
    rd(12'h800, 1, "R1 config");
    step();

    // R2 direction and drive
    wr(12'h803, 8'h00);
    wr(12'h903, 8'h01);
    check(pin_oe[3] == 1, "R2 oe3", pin_oe[3], 1);
    check(pin_out[3] == 1, "R2 out3", pin_out[3], 1);
    rd(12'h803, 0, "R2 cfg3");

    // R3 input readback and read-zero cases
    pin_in[5] = 1;
    rd(12'hA05, 0, "R3 before");
    step();
    rd(12'hA05, 0, "R3 one edge");
    step();
    rd(12'hA05, 1, "R3 two edges");
    rd(12'hE05, 0, "R3 clear bank");
    rd(12'h7FF, 0, "R3 outside");
    rd(12'h820, 0, "R3 index range");

    // R4 level-high on pin 1, R8 masking
    wr(12'hC01, 8'h01);
    wr(12'hE01, 8'h01);
    steps(2);
    rd(12'hF01, 0, "R4 inactive level");
    pin_in[1] = 1;
    steps(3);
    rd(12'hF01, 1, "R4 active level");
    check(irq == 0, "R8 masked", irq, 0);
    wr(12'hB01, 8'h01);
    steps(2);
    check(irq == 1, "R8 unmasked", irq, 1);
    wr(12'hE01, 8'h01);
    rd(12'hF01, 1, "R7 level persists");
    pin_in[1] = 0;
    steps(3);
    wr(12'hE01, 8'h01);
    rd(12'hF01, 0, "R7 cleared");
    steps(2);
    check(irq == 0, "R8 deasserted", irq, 0);
    wr(12'hB01, 8'h00);

    // R7 set wins: pin 7 default level-low, pin low
    wr(12'hE07, 8'h01);
    rd(12'hF07, 1, "R7 set wins");

    // R5 falling edge on pin 2
    wr(12'hD02, 8'h01);
    wr(12'hE02, 8'h01);
    rd(12'hF02, 0, "R5 cleared");
    pin_in[2] = 1;
    steps(4);
    rd(12'hF02, 0, "R5 rise ignored");
    pin_in[2] = 0;
    steps(3);
    rd(12'hF02, 1, "R5 fall detected");

    // R6 dual edge on pin 4, polarity set but ignored
    wr(12'hD04, 8'h01);
    wr(12'hF84, 8'h01);
    wr(12'hC04, 8'h01);
    wr(12'hE04, 8'h01);
    rd(12'hF04, 0, "R6 cleared");
    pin_in[4] = 1;
    steps(3);
    rd(12'hF04, 1, "R6 rise");
    wr(12'hE04, 8'h01);
    rd(12'hF04, 0, "R6 recleared");
    pin_in[4] = 0;
    steps(3);
    rd(12'hF04, 1, "R6 fall");

    // R9 latency on pin 6, rising edge, enabled
    wr(12'hD06, 8'h01);
    wr(12'hC06, 8'h01);
    wr(12'hB06, 8'h01);
    wr(12'hE06, 8'h01);
    steps(2);
    addr = 12'hF06;
    pin_in[6] = 1;
    step();
    rd(12'hF06, 0, "R9 edge k");
    step();
    rd(12'hF06, 0, "R9 edge k+1");
    step();
    rd(12'hF06, 1, "R9 status k+2");
    check(irq == 0, "R9 irq k+2", irq, 0);
    step();
    check(irq == 1, "R9 irq k+3", irq, 1);
    steps(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule